// File: doc/BRIEF.md
# Programmable Sample-Rate Strobe Generator with Phase Trim

This block derives a one-cycle sample strobe from a 24.576 MHz master clock. Software sets the sample rate as a whole number of hertz through a 16-bit rate register. A phase accumulator adds that value on every master-clock cycle. Each time the accumulator reaches the master-clock frequency, the modulus is taken off and a strobe is emitted. Over a long window, this gives exactly the requested number of strobes per second.

A second register queues a phase trim. The trim is a step count with a direction flag. The block does not apply it at once. It works the trim off at one step every eighth master-clock cycle. Each step moves the accumulator by 1/3000 of a sample period, earlier or later. The register always reads back the steps that are still pending. Both registers go back to their defaults, and refuse writes, while the reset input or the power-down input is low.

Top module: `sample_clk_gen`

## Requirements
- R1: Over any window of N master-clock cycles where N·rate is a whole multiple of 24,576,000, the strobe is high for exactly N·rate/24,576,000 cycles, and it is never high on two consecutive cycles.
- R2: The rate register is selected by select value 0, is 16 bits wide and holds 0xBB80 (48,000) after reset. A written in-range value reads back unchanged on the next cycle.
- R3: A rate write below 0x0FA0 is stored as 0x0FA0, and a rate write above 0xD2F0 is stored as 0xD2F0.
- R4: While `rst_n` or `pwrdn_n` is low, the rate register holds 0xBB80 and the trim register reads 0. Writes to either register in that state have no effect.
- R5: The trim register is selected by select value 1. Bits 7:0 hold the step count and bit 8 holds the direction (0 = advance, 1 = retard). Bits 15:9 read 0. A write replaces any pending count and is not added to it.
- R6: A nonzero pending count drops by exactly one on every eighth master-clock cycle until it reaches 0. The read-back value always shows the count that remains.
- R7: Each advance step adds 8192 to the accumulator. After a full advance trim of M steps, strobes land M·8192/rate cycles earlier than before.
- R8: Each retard step subtracts 8192 from the accumulator without creating an extra strobe. After a full retard trim of M steps, strobes land M·8192/rate cycles later than before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down; holds the registers at their defaults |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 rate, 1 trim |
| wr_data | input | 16 | Write value |
| rd_sel | input | 1 | Read target: 0 rate, 1 trim |
| rd_data | output | 16 | Read value (combinational from the registers) |
| smp_strobe | output | 1 | One-cycle sample strobe |

## Verification
The hardest effect to observe is the trim's net shift of the strobe grid. The shift is spread over about a thousand cycles and several strobes, and for most rates and step counts it is not a whole number of cycles. To make it exact, the stimulus runs at 32,000 Hz and queues 125 steps, which moves the grid by exactly 32 cycles. The bench timestamps one strobe before the write and one after the count has drained, and compares their distance modulo the 768-cycle period. The rate windows are also chosen so that the strobe count is exact whatever the accumulator's starting value.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  typedef enum logic {
    SEL_RATE  = 1'b0,
    SEL_TRIM  = 1'b1
  } reg_sel_e;

  // Clamp a value into [lo, hi].
  function automatic int unsigned clamp_u(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Signed accumulator adjustment for one trim step.
  function automatic int trim_adj(logic en, logic retard, int step);
    if (!en) return 0;
    return retard ? -step : step;
  endfunction

endpackage

// File: rtl/sclk_rate.sv
module sclk_rate
  import sclk_pkg::*;
#(
  parameter int RATE_W   = 16,
  parameter int RATE_MIN = 4000,
  parameter int RATE_MAX = 54000,
  parameter int RATE_DEF = 48000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn_n,
  input  logic              load,
  input  logic [RATE_W-1:0] load_val,
  output logic [RATE_W-1:0] rate_q
);

  logic [RATE_W-1:0] clamped;
  assign clamped = RATE_W'(clamp_u(32'(load_val), RATE_MIN, RATE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rate_q <= RATE_W'(RATE_DEF);
    else if (!pwrdn_n) rate_q <= RATE_W'(RATE_DEF);
    else if (load)     rate_q <= clamped;
  end

  p_rate_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rate_q) >= RATE_MIN) && (32'(rate_q) <= RATE_MAX));

  p_pd_rate_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> rate_q == RATE_W'(RATE_DEF));

endmodule

// File: rtl/sclk_trim.sv
module sclk_trim #(
  parameter int MAG_W = 8,
  parameter int PRESC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrdn_n,
  input  logic             load,
  input  logic [MAG_W-1:0] load_mag,
  input  logic             load_dir,
  output logic [MAG_W-1:0] mag_q,
  output logic             dir_q,
  output logic             step
);

  localparam int PW = $clog2(PRESC);

  logic [PW-1:0] presc_q;
  logic          tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= (presc_q == PW'(PRESC - 1)) ? '0 : presc_q + 1'b1;
  end

  assign tick = (presc_q == PW'(PRESC - 1));
  assign step = tick && (mag_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mag_q <= '0;
      dir_q <= 1'b0;
    end else if (!pwrdn_n) begin
      mag_q <= '0;
      dir_q <= 1'b0;
    end else if (load) begin
      mag_q <= load_mag;
      dir_q <= load_dir;
    end else if (step) begin
      mag_q <= mag_q - 1'b1;
    end
  end

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && pwrdn_n) |=> mag_q == $past(mag_q) - 1'b1);

  p_step_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);

  p_pd_trim_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> (mag_q == '0) && !dir_q);

endmodule

// File: rtl/sclk_accum.sv
module sclk_accum
  import sclk_pkg::*;
#(
  parameter int MOD    = 24576000,
  parameter int RATE_W = 16,
  parameter int STEP   = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              step,
  input  logic              step_dir,
  output logic              strobe
);

  localparam int AW = $clog2(MOD) + 2;

  logic signed [AW-1:0] acc_q;
  int                   sum_i;
  logic                 wrap_evt;

  always_comb begin
    sum_i    = int'(acc_q) + int'({1'b0, rate}) + trim_adj(step, step_dir, STEP);
    wrap_evt = (sum_i >= MOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else begin
      acc_q  <= wrap_evt ? AW'(sum_i - MOD) : AW'(sum_i);
      strobe <= wrap_evt;
    end
  end

  p_acc_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_q) >= -STEP) && (int'(acc_q) < MOD));

  p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  p_advance_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_dir && !wrap_evt) |=> int'(acc_q) == $past(int'(acc_q)) + int'({1'b0, $past(rate)}) + STEP);

endmodule

// File: rtl/sample_clk_gen.sv
module sample_clk_gen
  import sclk_pkg::*;
#(
  parameter int MCLK_HZ    = 24576000,
  parameter int RATE_W     = 16,
  parameter int MAG_W      = 8,
  parameter int RATE_MIN   = 4000,
  parameter int RATE_MAX   = 54000,
  parameter int RATE_DEF   = 48000,
  parameter int PRESC      = 8,
  parameter int TRIM_SPLIT = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrdn_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [RATE_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [RATE_W-1:0] rd_data,
  output logic              smp_strobe
);

  localparam int STEP = MCLK_HZ / TRIM_SPLIT;

  reg_sel_e          wsel, rsel;
  logic              rate_load, trim_load;
  logic [RATE_W-1:0] rate_q;
  logic [MAG_W-1:0]  mag_q;
  logic              dir_q, step;

  assign wsel      = reg_sel_e'(wr_sel);
  assign rsel      = reg_sel_e'(rd_sel);
  assign rate_load = wr_en && (wsel == SEL_RATE);
  assign trim_load = wr_en && (wsel == SEL_TRIM);

  sclk_rate #(
    .RATE_W(RATE_W), .RATE_MIN(RATE_MIN), .RATE_MAX(RATE_MAX), .RATE_DEF(RATE_DEF)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .load(rate_load), .load_val(wr_data), .rate_q(rate_q)
  );

  sclk_trim #(.MAG_W(MAG_W), .PRESC(PRESC)) u_trim (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .load(trim_load), .load_mag(wr_data[MAG_W-1:0]), .load_dir(wr_data[MAG_W]),
    .mag_q(mag_q), .dir_q(dir_q), .step(step)
  );

  sclk_accum #(.MOD(MCLK_HZ), .RATE_W(RATE_W), .STEP(STEP)) u_accum (
    .clk(clk), .rst_n(rst_n), .rate(rate_q),
    .step(step), .step_dir(dir_q), .strobe(smp_strobe)
  );

  always_comb begin
    if (rsel == SEL_RATE) rd_data = rate_q;
    else                  rd_data = RATE_W'({dir_q, mag_q});
  end

  p_reset_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rate_q == RATE_W'(RATE_DEF));

endmodule

// File: tb/sample_clk_gen_tb.sv
module sample_clk_gen_tb;

  localparam int MOD = 24576000;

  typedef struct packed {
    logic [15:0] wr;
    logic [15:0] rd;
    int          n;
    int          k;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'hBB80, 16'hBB80, 4096, 8},
    '{16'h7D00, 16'h7D00, 3072, 4},
    '{16'h3E80, 16'h3E80, 3072, 2},
    '{16'hD2F0, 16'hD2F0, 4096, 9},
    '{16'h03E8, 16'h0FA0, 6144, 1},
    '{16'hFFFF, 16'hD2F0, 4096, 9},
    '{16'h0F9F, 16'h0FA0, 6144, 1},
    '{16'hD2F1, 16'hD2F0, 4096, 9}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, pwrdn_n = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        smp_strobe;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sample_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .smp_strobe(smp_strobe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, output int v);
    rd_sel = sel;
    #1;
    v = int'(rd_data);
  endtask

  task automatic count_win(int n, output int c, output int adj);
    logic prev = 1'b0;
    c = 0; adj = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (smp_strobe) c++;
      if (smp_strobe && prev) adj++;
      prev = smp_strobe;
    end
  endtask

  task automatic next_strobe(output int t);
    do @(negedge clk); while (!smp_strobe);
    t = cyc;
  endtask

  task automatic trim_shift(logic [15:0] code, int exp_mod, string req);
    int t0, t1, v;
    next_strobe(t0);
    wr(1'b1, code);
    rd(1'b1, v);  chk({req, "/R5 trim readback after write"}, v, int'(code));
    repeat (400) @(negedge clk);
    rd(1'b1, v);  chk("R6 remaining after 400 cycles", v & 8'hFF, 75);
    repeat (700) @(negedge clk);
    rd(1'b1, v);  chk("R6 remaining drained", v & 8'hFF, 0);
    next_strobe(t1);
    chk({req, " strobe grid shift"}, (t1 - t0) % 768, exp_mod);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, c, adj;
    repeat (3) @(negedge clk);
    rd(1'b0, v); chk("R4 rate during reset", v, 16'hBB80);
    rd(1'b1, v); chk("R4 trim during reset", v, 0);
    chk("R4 strobe low during reset", int'(smp_strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk("R2 rate default", v, 16'hBB80);

    // R1/R2/R3 table walk
    foreach (VEC[i]) begin
      wr(1'b0, VEC[i].wr);
      rd(1'b0, v); chk("R2/R3 rate readback", v, int'(VEC[i].rd));
      repeat (3) @(negedge clk);
      count_win(VEC[i].n, c, adj);
      chk("R1 strobe count", c, VEC[i].k);
      chk("R1 no adjacent strobes", adj, 0);
    end

    // R5: upper bits dropped, replace not accumulate
    wr(1'b1, 16'hFE05);
    rd(1'b1, v); chk("R5 upper bits read zero", v, 16'h0005);
    wr(1'b1, 16'h0064);
    repeat (80) @(negedge clk);
    rd(1'b1, v); chk("R6 count after 80 cycles", v, 16'h005A);
    wr(1'b1, 16'h0103);
    rd(1'b1, v); chk("R5 write replaces pending", v, 16'h0103);
    repeat (40) @(negedge clk);

    // R7/R8: exact 32-cycle shift at 32 kHz with 125 steps
    wr(1'b0, 16'h7D00);
    repeat (2000) @(negedge clk);
    trim_shift(16'h007D, 736, "R7");
    trim_shift(16'h017D, 32, "R8");
    count_win(3072, c, adj);
    chk("R8 count after retard", c, 4);

    // R4: power-down
    wr(1'b0, 16'h7D00);
    wr(1'b1, 16'h0150);
    pwrdn_n = 1'b0;
    @(negedge clk);
    rd(1'b0, v); chk("R4 rate forced in power-down", v, 16'hBB80);
    rd(1'b1, v); chk("R4 trim cleared in power-down", v, 0);
    wr(1'b0, 16'h3E80);
    wr(1'b1, 16'h0020);
    rd(1'b0, v); chk("R4 rate write ignored", v, 16'hBB80);
    rd(1'b1, v); chk("R4 trim write ignored", v, 0);
    pwrdn_n = 1'b1;
    @(negedge clk);
    count_win(4096, c, adj);
    chk("R4 default rate after power-down", c, 8);

    // R4: reset pulse
    wr(1'b0, 16'h3E80);
    wr(1'b1, 16'h0040);
    rst_n = 1'b0;
    @(negedge clk);
    wr(1'b0, 16'h7D00);
    rd(1'b0, v); chk("R4 rate write ignored in reset", v, 16'hBB80);
    rd(1'b1, v); chk("R4 trim cleared by reset", v, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk("R2 rate after reset", v, 16'hBB80);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule